// File: doc/BRIEF.md
# Serial Memory Target Front End with Pause Input

This block is the bit-level front end of a serial memory target running in clock mode 0. It watches chip select, serial clock, serial data in and an active-low pause input. It assembles incoming bits into bytes, most significant bit first, and hands each finished byte to the command logic as a one-cycle strobe. It also shifts a response byte supplied by the command logic out on the data output. The first byte after chip select falls is marked as the instruction byte.

The pause input lets a bus master borrow the shared serial lines in the middle of a transaction. While the target is paused, its output enable is dropped and serial clock and data-in activity is ignored. The bit position, the partly received byte, the outgoing shift state and the instruction flag are all kept. After the pause, shifting picks up at the same bit. The pause starts or ends at once when the serial clock is low. When the serial clock is high, the change waits for its next falling edge. All pins are sampled into the system clock domain, which must run at least four times faster than the serial clock.

Top module: `spi_hold_target`

## Requirements
- R1: With chip select high, the pause input has no effect, and chip select high always leaves the target un-paused; a pause pulse given while deselected leaves the output enabled once chip select falls.
- R2: When the pause input falls while chip select is low and the serial clock is low, the pause starts at once and `dout_oe` drops.
- R3: When the pause input falls while the serial clock is high, the pause starts only after the next serial clock falling edge; until then `dout_oe` stays high.
- R4: A pause input rise with the serial clock low ends the pause at once. With the serial clock high, the pause ends only after the next serial clock falling edge.
- R5: While paused, `dout_oe` is low and serial clock edges and data-in values change nothing. Reception resumes at the same bit with no lost, extra or corrupted bit.
- R6: Chip select high discards the bit count, the partial byte and the instruction context, including during a pause. The next byte after chip select falls is flagged as an instruction.
- R7: Data in is sampled on serial clock rising edges, MSB first. Each completed byte raises `rx_valid` for exactly one system cycle with the byte on `rx_byte`. `rx_cmd` is 1 for the first byte after chip select falls and 0 for later bytes.
- R8: `dout` presents `tx_byte` MSB first and advances on serial clock falling edges. `tx_byte` is loaded while deselected and again at each byte boundary. `dout_oe` is high exactly when selected and not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low (asynchronous pin) |
| sck | input | 1 | Serial clock, idle low (asynchronous pin) |
| di | input | 1 | Serial data in (asynchronous pin) |
| hold_n | input | 1 | Pause request, active low (asynchronous pin) |
| tx_byte | input | 8 | Response byte from the command logic |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout` |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_cmd | output | 1 | Completed byte is the instruction byte |
| rx_byte | output | 8 | Completed byte |

## Verification
The assertions assume the synchronized pins move no faster than the edge detector can resolve. Each serial clock level must last several system cycles, and the pause input must not change in the same system cycle as a serial clock edge. The bench holds every pin level for four system cycles and changes only one pin at a time, so each edge and each pause transition is seen alone after the two-stage synchronizer. It also checks each enable change four cycles after the pin moves, by which time the synchronizer and the state register have both settled.

// File: rtl/spi_hold_pkg.sv
// Shared types for the serial target front end.
// Assumes: pin bundle order is fixed; reset level of each pin is its idle level.
package spi_hold_pkg;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic di;
        logic hold_n;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);
    localparam pins_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, di: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/spi_hold_sync.sv
// Multi-bit pin synchronizer: each bit passes through STAGES flops.
// Assumes: bits are independent levels; no bus coherence is needed.
module spi_hold_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Move each pin level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d_async;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
// Pause state tracker. A change of pause request is accepted only while the
// synchronized serial clock is low, so a request made with the clock high
// takes effect after its next falling edge. Deselect clears the pause.
// Assumes: inputs are already synchronized.
module spi_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic hold_act
);
    // Update the pause flag only when selected and the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) hold_act <= 1'b0;
        else if (!sck_s)      hold_act <= !hold_n_s;
    end

    assert_deselect_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !hold_act);
    assert_enter_low_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !sck_s && !hold_n_s) |=> hold_act);
    assert_no_entry_clock_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && sck_s && !hold_act) |=> !hold_act);
    assert_no_exit_clock_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && sck_s && hold_act) |=> hold_act);
endmodule

// File: rtl/spi_hold_shifter.sv
// Byte shifter: samples data in on serial clock rises, shifts the response
// out on falls, and flags the first byte of a selection as the instruction.
// All shift state freezes while paused and clears while deselected.
// Assumes: synchronized inputs; serial clock levels last >= 2 system cycles.
module spi_hold_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              di_s,
    input  logic              hold_act,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              dout,
    output logic              rx_valid,
    output logic              rx_cmd,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic              sck_q;
    logic              first_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_next;
    logic              sck_rise, sck_fall, live;

    // Detect serial clock edges and gate them with select and pause.
    always_comb begin
        sck_rise = sck_s && !sck_q;
        sck_fall = !sck_s && sck_q;
        live     = !cs_n_s && !hold_act;
        rx_next  = {rx_sr[BYTE_W-2:0], di_s};
    end

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Receive path: shift in on rises, emit a strobe per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            first_q  <= 1'b1;
            rx_valid <= 1'b0;
            rx_cmd   <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
                rx_sr   <= '0;
                first_q <= 1'b1;
            end else if (live && sck_rise) begin
                rx_sr <= rx_next;
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    rx_valid <= 1'b1;
                    rx_byte  <= rx_next;
                    rx_cmd   <= first_q;
                    first_q  <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Transmit path: preload while deselected, shift or reload on falls.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s)       tx_sr <= tx_byte;
        else if (live && sck_fall) begin
            if (bit_cnt == '0) tx_sr <= tx_byte;
            else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign dout = tx_sr[BYTE_W-1];

    assert_frozen_in_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_act && !cs_n_s) |=> ($stable(bit_cnt) && $stable(rx_sr) && $stable(tx_sr)));
    assert_deselect_clears_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == '0 && first_q));
    assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_no_strobe_in_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_act || cs_n_s) |=> !rx_valid);
endmodule

// File: rtl/spi_hold_target.sv
// Top of the serial target front end: synchronizes the pins, tracks the
// pause state and runs the byte shifter.
// Assumes: system clock at least 4x the serial clock; serial clock mode 0.
module spi_hold_target #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              di,
    input  logic              hold_n,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              dout,
    output logic              dout_oe,
    output logic              rx_valid,
    output logic              rx_cmd,
    output logic [BYTE_W-1:0] rx_byte
);
    import spi_hold_pkg::*;

    pins_t pins_raw, pins_s;
    logic  hold_act;

    assign pins_raw = '{cs_n: cs_n, sck: sck, di: di, hold_n: hold_n};

    spi_hold_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pins_raw),
        .d_sync (pins_s)
    );

    spi_hold_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s.cs_n),
        .sck_s   (pins_s.sck),
        .hold_n_s(pins_s.hold_n),
        .hold_act(hold_act)
    );

    spi_hold_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s.cs_n),
        .sck_s   (pins_s.sck),
        .di_s    (pins_s.di),
        .hold_act(hold_act),
        .tx_byte (tx_byte),
        .dout    (dout),
        .rx_valid(rx_valid),
        .rx_cmd  (rx_cmd),
        .rx_byte (rx_byte)
    );

    assign dout_oe = !pins_s.cs_n && !hold_act;

    assert_oe_low_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pins_s.cs_n |-> !dout_oe);
    assert_oe_low_paused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |-> !dout_oe);
endmodule

// File: tb/sim_spi_hold_target.sv
module sim_spi_hold_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, di = 1'b0, hold_n = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic dout, dout_oe, rx_valid, rx_cmd;
    logic [7:0] rx_byte;

    int total = 0;
    int bad = 0;
    int n_got = 0;
    logic [7:0] got_byte [8];
    logic       got_cmd  [8];

    always #10 clk = ~clk;

    spi_hold_target u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .di(di), .hold_n(hold_n),
        .tx_byte(tx_byte), .dout(dout), .dout_oe(dout_oe),
        .rx_valid(rx_valid), .rx_cmd(rx_cmd), .rx_byte(rx_byte)
    );

    // Record every completed byte, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (n_got < 8) begin
                got_byte[n_got] = rx_byte;
                got_cmd[n_got]  = rx_cmd;
            end
            n_got = n_got + 1;
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Garbage clock pulses with random data while paused.
    task automatic junk_pulses();
        for (int k = 0; k < 3; k++) begin
            di = ~di; sck = 1'b1; settle();
            sck = 1'b0; settle();
        end
    endtask

    // One transaction of three bytes; mode 1 = pause with clock low before
    // bit pos of byte 1, mode 2 = pause with clock high after that bit's rise.
    task automatic run_txn(input logic [7:0] c, input logic [7:0] d1,
                           input logic [7:0] d2, input logic [7:0] txb,
                           input int mode, input int pos);
        logic [23:0] stream;
        stream  = {c, d1, d2};
        tx_byte = txb;
        settle();
        n_got = 0;
        cs_n = 1'b0; settle();
        check("R8 oe selected", dout_oe, 1);
        for (int b = 0; b < 24; b++) begin
            if (mode == 1 && b == 8 + pos) begin
                hold_n = 1'b0; settle();
                check("R2 oe low at pause", dout_oe, 0);
                junk_pulses();
                check("R5 no strobe in pause", n_got, 1);
                hold_n = 1'b1; settle();
                check("R4 oe back at release", dout_oe, 1);
            end
            di = stream[23-b]; settle();
            check("R8 dout bit", dout, txb[7 - (b % 8)]);
            sck = 1'b1; settle();
            if (mode == 2 && b == 8 + pos) begin
                hold_n = 1'b0; settle();
                check("R3 oe waits for fall", dout_oe, 1);
                sck = 1'b0; settle();
                check("R3 oe low after fall", dout_oe, 0);
                junk_pulses();
                sck = 1'b1; settle();
                hold_n = 1'b1; settle();
                check("R4 pause kept clock high", dout_oe, 0);
                sck = 1'b0; settle();
                check("R4 oe back after fall", dout_oe, 1);
            end else begin
                sck = 1'b0; settle();
            end
        end
        cs_n = 1'b1; settle();
        check("R8 oe deselected", dout_oe, 0);
        check("R7 byte count", n_got, 3);
        check("R7 cmd byte", got_byte[0], c);
        check("R7 cmd flag", got_cmd[0], 1);
        check("R5 data byte 1", got_byte[1], d1);
        check("R7 data flag 1", got_cmd[1], 0);
        check("R7 data byte 2", got_byte[2], d2);
        check("R7 data flag 2", got_cmd[2], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset oe", dout_oe, 0);
        check("R7 reset strobe", rx_valid, 0);
        rst_n = 1'b1;
        settle();

        // R1: pause pulse while deselected has no effect.
        hold_n = 1'b0; settle();
        hold_n = 1'b1; settle();
        cs_n = 1'b0; settle();
        check("R1 oe after deselected pause", dout_oe, 1);
        cs_n = 1'b1; settle();
        hold_n = 1'b0; settle();
        cs_n = 1'b0; settle();
        hold_n = 1'b1; settle();
        check("R1 pause cleared by release", dout_oe, 1);
        cs_n = 1'b1; settle();

        // Sweep over bit positions and pause modes.
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 3; m++) begin
                run_txn(8'(i * 37 + 3), 8'(8'hA5 ^ (i << m)), 8'(i * 29 + m),
                        8'(8'h96 + i * 11 + m), m, i);
            end
        end

        // R6: deselect during a pause drops the partial instruction.
        n_got = 0;
        cs_n = 1'b0; settle();
        for (int b = 0; b < 5; b++) begin
            di = 1'b1; settle(); sck = 1'b1; settle(); sck = 1'b0; settle();
        end
        hold_n = 1'b0; settle();
        cs_n = 1'b1; settle();
        hold_n = 1'b1; settle();
        check("R6 no partial byte", n_got, 0);
        check("R6 oe low after abort", dout_oe, 0);
        run_txn(8'h3C, 8'hC3, 8'h5A, 8'hE1, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule